// File: doc/BRIEF.md
# Variable-Width Sum-of-Products Array

This block is a configurable AND-OR logic plane. Its input columns are a set of dedicated inputs together with one feedback line from each output cell. It produces one sum term per output, one output-enable product term per output, and two shared control terms, one for synchronous preset and one for asynchronous reset. The outputs do not all get the same number of product terms. They are grouped in pairs, and the budget grows from 8 to 16 terms in steps of 2, so two outputs share each count.

The block holds its connection pattern in configuration rows, one row per product term. Rows are written through an addressed write port. A lock input then freezes the configuration until the next reset. A small control FSM has two states. `ST_OPEN` accepts row writes. On `cfg_lock` it takes the transition `OPEN_TO_LOCKED` into `ST_LOCKED`. In `ST_LOCKED` every write is ignored, and the only exit is the reset transition `ANY_TO_OPEN`. The path from the array inputs to every term output is purely combinational.

Top module: `pal_sop_array`

## Requirements
- R1: While reset is asserted, and just after it is released, every configuration row holds all ones. As a result `sum_out`, `oe_out`, `preset_pt` and `areset_pt` are all 0, and `cfg_locked` is 0.
- R2: A configuration row is 44 bits wide. Bit 2j selects the true literal of column j and bit 2j+1 selects its complement. Columns 0 to 11 are `ded_in[11:0]` and columns 12 to 21 are `fb_in[9:0]`.
- R3: A product term whose row is all zeros evaluates to 1. A term with both bits of one column set evaluates to 0 for any input.
- R4: Output i owns 8+2*(i/2) consecutive term addresses. They start at the sum of the counts of all lower outputs, so output 2 uses 16 to 25, output 3 starts at 26, output 4 starts at 36, output 8 uses 88 to 103 and output 9 uses 104 to 119. The output-enable term of output i sits at 120+i, the preset term at 130 and the reset term at 131.
- R5: `sum_out[i]` is the OR of the product terms that output i owns. If none of them is true, it is 0.
- R6: In `ST_OPEN`, a clock edge with `cfg_we` high stores `cfg_row` at `cfg_addr`. The new row takes effect right after that edge.
- R7: A write to an address of 132 or above changes no row.
- R8: `cfg_lock` in `ST_OPEN` moves the FSM to `ST_LOCKED`, and `cfg_locked` then reads 1. A write in that same cycle is still stored. After that, writes are ignored, and the FSM stays locked until reset.
- R9: A change on `ded_in` or `fb_in` reaches the term outputs without any clock edge.
- R10: `oe_out`, `preset_pt` and `areset_pt` are driven only by their own dedicated terms and do not depend on any sum term row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 8 | Product term address of the write |
| cfg_row | input | 44 | Row data, two bits per column |
| cfg_lock | input | 1 | Freeze request |
| ded_in | input | 12 | Dedicated array inputs |
| fb_in | input | 10 | Feedback from the output cells |
| sum_out | output | 10 | Sum term per output |
| oe_out | output | 10 | Output-enable term per output |
| preset_pt | output | 1 | Shared synchronous-preset term |
| areset_pt | output | 1 | Shared asynchronous-reset term |
| cfg_locked | output | 1 | High in `ST_LOCKED` |

## Verification
The bench targets the term allocation boundaries: the last term of output 2, the last term of output 8, and the first terms of outputs 3 and 4. A wrong base or count function would light up a neighbouring output instead of the intended one. It also checks the empty-term and contradictory-literal cases, where a wrong polarity would invert whole outputs. For locking, it writes in the same cycle as the lock and again afterwards. A design that takes the lock one cycle early drops the first write, and one that leaks writes changes output 4. An out-of-range write and a mid-cycle input change cover address aliasing and any unwanted registering of the array path.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } cfg_state_e;

    // number of product terms owned by output i (pairs share a count)
    function automatic int pt_count(int i, int pmin, int pstep);
        return pmin + pstep * (i / 2);
    endfunction

    // first term address of output i
    function automatic int pt_base(int i, int pmin, int pstep);
        int s;
        s = 0;
        for (int k = 0; k < i; k++) begin
            s += pt_count(k, pmin, pstep);
        end
        return s;
    endfunction

endpackage

// File: rtl/pal_pterm.sv
`timescale 1ns/1ps
module pal_pterm #(
    parameter int N_COL = 22
) (
    input  logic [N_COL-1:0]   col,
    input  logic [2*N_COL-1:0] row,
    output logic               pt
);
    logic [N_COL-1:0] kill;

    always_comb begin
        for (int j = 0; j < N_COL; j++) begin
            kill[j] = (row[2*j] & ~col[j]) | (row[2*j+1] & col[j]);
        end
        pt = ~|kill;
    end
endmodule

// File: rtl/pal_sum_or.sv
`timescale 1ns/1ps
module pal_sum_or #(
    parameter int N_T = 8
) (
    input  logic [N_T-1:0] pts,
    output logic           y
);
    assign y = |pts;
endmodule

// File: rtl/pal_cfg_store.sv
`timescale 1ns/1ps
module pal_cfg_store
    import pal_pkg::*;
#(
    parameter int ROW_W  = 44,
    parameter int N_PT   = 132,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [ROW_W-1:0]           cfg_row,
    input  logic                       cfg_lock,
    output logic [N_PT-1:0][ROW_W-1:0] fuse_q,
    output logic                       cfg_locked
);
    cfg_state_e state_q, state_d;
    logic       wr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        wr_ok   = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                wr_ok = cfg_we;
                if (cfg_lock) state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                wr_ok = 1'b0;
            end
        endcase
    end

    assign cfg_locked = (state_q == ST_LOCKED);

    for (genvar g = 0; g < N_PT; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                fuse_q[g] <= '1;
            else if (wr_ok && cfg_addr == ADDR_W'(g))
                fuse_q[g] <= cfg_row;
        end
    end
endmodule

// File: rtl/pal_sop_array.sv
`timescale 1ns/1ps
module pal_sop_array #(
    parameter int N_DED   = 12,
    parameter int N_OUT   = 10,
    parameter int PT_MIN  = 8,
    parameter int PT_STEP = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [$clog2(pal_pkg::pt_base(N_OUT, PT_MIN, PT_STEP) + N_OUT + 2)-1:0] cfg_addr,
    input  logic [2*(N_DED+N_OUT)-1:0]             cfg_row,
    input  logic                                   cfg_lock,
    input  logic [N_DED-1:0]                       ded_in,
    input  logic [N_OUT-1:0]                       fb_in,
    output logic [N_OUT-1:0]                       sum_out,
    output logic [N_OUT-1:0]                       oe_out,
    output logic                                   preset_pt,
    output logic                                   areset_pt,
    output logic                                   cfg_locked
);
    localparam int N_COL   = N_DED + N_OUT;
    localparam int ROW_W   = 2 * N_COL;
    localparam int N_SUM   = pal_pkg::pt_base(N_OUT, PT_MIN, PT_STEP);
    localparam int OE_BASE = N_SUM;
    localparam int PRE_IDX = N_SUM + N_OUT;
    localparam int AR_IDX  = PRE_IDX + 1;
    localparam int N_PT    = AR_IDX + 1;
    localparam int ADDR_W  = $clog2(N_PT);

    logic [N_PT-1:0][ROW_W-1:0] fuse_q;
    logic [N_COL-1:0]           col;
    logic [N_PT-1:0]            pt_all;

    assign col = {fb_in, ded_in};

    pal_cfg_store #(
        .ROW_W (ROW_W),
        .N_PT  (N_PT),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_row   (cfg_row),
        .cfg_lock  (cfg_lock),
        .fuse_q    (fuse_q),
        .cfg_locked(cfg_locked)
    );

    for (genvar t = 0; t < N_PT; t++) begin : g_pt
        pal_pterm #(.N_COL(N_COL)) u_pt (
            .col(col),
            .row(fuse_q[t]),
            .pt (pt_all[t])
        );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int B = pal_pkg::pt_base(o, PT_MIN, PT_STEP);
        localparam int C = pal_pkg::pt_count(o, PT_MIN, PT_STEP);
        pal_sum_or #(.N_T(C)) u_or (
            .pts(pt_all[B+C-1:B]),
            .y  (sum_out[o])
        );
        assign oe_out[o] = pt_all[OE_BASE+o];
    end

    assign preset_pt = pt_all[PRE_IDX];
    assign areset_pt = pt_all[AR_IDX];
endmodule

// File: rtl/pal_sop_chk.sv
`timescale 1ns/1ps
module pal_sop_chk #(
    parameter int ROW_W  = 44,
    parameter int N_PT   = 132,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic [ADDR_W-1:0]          cfg_addr,
    input logic [ROW_W-1:0]           cfg_row,
    input logic                       cfg_lock,
    input logic                       cfg_locked,
    input logic [N_PT-1:0][ROW_W-1:0] fuse_q
);
    logic              wr_seen_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ROW_W-1:0]  row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen_q <= 1'b0;
            addr_q    <= '0;
            row_q     <= '0;
        end else begin
            wr_seen_q <= cfg_we && !cfg_locked && (cfg_addr < ADDR_W'(N_PT));
            addr_q    <= cfg_addr;
            row_q     <= cfg_row;
        end
    end

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked);

    p_lock_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_locked) |-> $past(cfg_lock));

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(fuse_q));

    p_oob_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr >= ADDR_W'(N_PT)) |=> $stable(fuse_q));

    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen_q |-> (fuse_q[addr_q] == row_q));
endmodule

bind pal_sop_array pal_sop_chk #(
    .ROW_W (ROW_W),
    .N_PT  (N_PT),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_row   (cfg_row),
    .cfg_lock  (cfg_lock),
    .cfg_locked(cfg_locked),
    .fuse_q    (fuse_q)
);

// File: tb/tb_pal_sop_array.sv
`timescale 1ns/1ps
module tb_pal_sop_array;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [43:0] cfg_row;
    logic        cfg_lock;
    logic [11:0] ded_in;
    logic [9:0]  fb_in;
    logic [9:0]  sum_out, oe_out;
    logic        preset_pt, areset_pt, cfg_locked;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pal_sop_array dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_row(cfg_row), .cfg_lock(cfg_lock), .ded_in(ded_in), .fb_in(fb_in),
        .sum_out(sum_out), .oe_out(oe_out), .preset_pt(preset_pt),
        .areset_pt(areset_pt), .cfg_locked(cfg_locked)
    );

    // {ded[43:32], fb[31:22], sum[21:12], oe[11:2], preset[1], areset[0]}
    localparam logic [43:0] VEC [7] = '{
        {12'h000, 10'h000, 10'h200, 10'h001, 1'b0, 1'b0},
        {12'h001, 10'h000, 10'h201, 10'h001, 1'b0, 1'b0},
        {12'h003, 10'h000, 10'h200, 10'h001, 1'b0, 1'b0},
        {12'h004, 10'h001, 10'h202, 10'h000, 1'b0, 1'b0},
        {12'h018, 10'h000, 10'h200, 10'h001, 1'b1, 1'b0},
        {12'h021, 10'h000, 10'h201, 10'h001, 1'b0, 1'b1},
        {12'hFFF, 10'h3FF, 10'h202, 10'h000, 1'b1, 1'b1}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [43:0] r, logic lk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_row = r; cfg_lock = lk;
        @(negedge clk);
        cfg_we = 1'b0; cfg_lock = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 sums in reset", 32'(sum_out), 32'h0);
        chk("R1 oe/ctl in reset", {20'h0, oe_out, preset_pt, areset_pt}, 32'h0);
        chk("R1 locked in reset", 32'(cfg_locked), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_row = '0; cfg_lock = 1'b0;
        ded_in = 12'hABC; fb_in = 10'h155;
        do_reset();
        chk("R1 blank after release", {12'h0, sum_out, oe_out}, 32'h0);

        // R2/R4/R10 configuration
        wr(8'd0,   44'h9,       1'b0);  // out0: d0 & ~d1
        wr(8'd8,   44'h1000000, 1'b0);  // out1: fb0
        wr(8'd119, 44'h0,       1'b0);  // out9: empty term -> 1 (R3)
        wr(8'd120, 44'h20,      1'b0);  // oe0: ~d2
        wr(8'd130, 44'h140,     1'b0);  // preset: d3 & d4
        wr(8'd131, 44'h400,     1'b0);  // areset: d5

        for (int v = 0; v < 7; v++) begin
            @(negedge clk);
            ded_in = VEC[v][43:32];
            fb_in  = VEC[v][31:22];
            #1;
            chk($sformatf("R2 R3 R5 R10 vector %0d", v),
                {10'h0, sum_out, oe_out, preset_pt, areset_pt}, {10'h0, VEC[v][21:0]});
        end

        // R9: input change inside one low phase, no clock edge between
        @(negedge clk);
        ded_in = 12'h001; fb_in = 10'h0;
        #0.5;
        chk("R9 first value", 32'(sum_out[0]), 32'h1);
        ded_in = 12'h003;
        #0.5;
        chk("R9 no edge", 32'(sum_out[0]), 32'h0);

        // R3: contradictory literal pair
        wr(8'd1, 44'h3, 1'b0);
        chk("R3 both literals", 32'(sum_out[0]), 32'h0);
        wr(8'd1, 44'h1, 1'b0);
        chk("R6 rewrite takes effect", 32'(sum_out[0]), 32'h1);
        wr(8'd1, 44'hFFF_FFFF_FFFF, 1'b0);

        // R4 allocation boundaries
        wr(8'd25, 44'h0, 1'b0);
        chk("R4 addr 25 is out2", 32'(sum_out & 10'h00C), 32'h004);
        wr(8'd103, 44'h0, 1'b0);
        chk("R4 addr 103 is out8", 32'(sum_out & 10'h300), 32'h300);
        wr(8'd121, 44'h0, 1'b0);
        chk("R4 R10 addr 121 is oe1", {12'h0, sum_out, oe_out}, {12'h0, 10'h304, 10'h003});

        // R7 out of range
        wr(8'd200, 44'h0, 1'b0);
        chk("R7 out of range write", {11'h0, sum_out, oe_out, preset_pt, areset_pt},
            {11'h0, 10'h304, 10'h003, 1'b0, 1'b0});

        // R8 lock with simultaneous write
        wr(8'd26, 44'h0, 1'b1);
        chk("R8 locked flag", 32'(cfg_locked), 32'h1);
        chk("R8 same-cycle write lands", 32'(sum_out), 32'h30C);
        wr(8'd36, 44'h0, 1'b0);
        chk("R8 write after lock ignored", 32'(sum_out), 32'h30C);
        chk("R8 stays locked", 32'(cfg_locked), 32'h1);

        // R1 again, then R6 write reopened
        do_reset();
        wr(8'd0, 44'h0, 1'b0);
        chk("R6 write after reset", {12'h0, sum_out, oe_out}, {12'h0, 10'h001, 10'h000});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule